// File: doc/BRIEF.md
# Receive Audio Concealment and Mute Controller

This block sits between a decoded receive subframe stream and a serial stereo output in I2S format. Once per stereo frame the upstream logic presents a left/right pair of 24-bit samples with three flags: parity error, biphase violation and the validity bit. It also presents a block-start marker. The block also watches the PLL lock flag, an external mute request, a word-length setting and an output-port enable.

Errors get different responses depending on their kind. A parity error or a biphase violation repeats the last correctly received stereo pair on both channels. A set validity bit passes the sample through unchanged and raises the invalid output for that sample. Lock loss zeroes both channels, and that mute is lifted only after a complete error-free block has arrived once lock has returned. All choices are made at the falling edge of word select, so every change of state takes effect at the start of a stereo sample.

The serial port generates its own bit clock at 64 periods per frame from the system clock. A bit period is `2*HALF_DIV` system clocks.

Top module: `rx_audio_guard`

## Requirements
- R1: A frame is 64 bit-clock periods. Word select is low for the left slot and high for the right slot. It changes while the bit clock is low, one bit period before each slot's MSB, so it is high in bit slots 31..62 and low in slots 63 and 0..30, counted from the left MSB. In each slot the 24 sample bits go out MSB first, followed by 8 zero bits. Serial data changes only on the falling edge of the bit clock.
- R2: `wlen_sel` sets how many leading bits of each sample are kept: 0 keeps 24, 1 keeps 20, 2 keeps 18 and 3 keeps 16. The remaining lower bits go out as zero.
- R3: A clean pair with the validity bit set is output unchanged, with `invalid_o` high for the whole frame. A clean pair with the validity bit clear has `invalid_o` low.
- R4: A pair flagged with a parity error or a biphase violation makes both channels repeat the last pair received without either error, together with that pair's validity. Before any such pair has been received, the repeated pair is zero with validity clear.
- R5: Lock is sampled at each falling edge of word select. If lock is low, both channels of the following frame are zero and `invalid_o` is low.
- R6: After lock loss, the mute holds while lock is present until a run of `BLK_FRAMES` consecutive clean pairs is received, counted from a pair carrying the block-start marker. That pair counts as the first of the run. An error or lock loss abandons the run, and counting begins again only at the next block-start pair. The pair that completes the run is already output unmuted.
- R7: When `mute_req` is high at a falling edge of word select, the next frame is zero with `invalid_o` low, whatever the validity bit. Once the request is withdrawn, data returns at the next frame.
- R8: When `port_en` is low, `sd_o` and `invalid_o` are driven low from the next clock. When it returns high, output resumes only at the next frame start, so a frame already in progress stays zero.
- R9: After reset, `sck_o`, `ws_o`, `sd_o` and `invalid_o` are low, and the first frame carries no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One-cycle strobe: a decoded stereo pair is present |
| in_left | input | 24 | Left sample |
| in_right | input | 24 | Right sample |
| in_par_err | input | 1 | Parity error seen in the pair |
| in_bph_err | input | 1 | Biphase violation outside the preambles |
| in_vbit | input | 1 | Validity bit of the pair (1 = unreliable) |
| in_blk_start | input | 1 | Pair is the first frame of a block |
| pll_lock | input | 1 | Receive clock recovery is locked |
| mute_req | input | 1 | External mute command |
| wlen_sel | input | 2 | Kept word length: 0=24, 1=20, 2=18, 3=16 |
| port_en | input | 1 | Serial data output enable |
| sck_o | output | 1 | Serial bit clock, 64 per frame |
| ws_o | output | 1 | Word select, low = left |
| sd_o | output | 1 | Serial data, MSB first |
| invalid_o | output | 1 | Invalid-sample flag for the current frame |

## Verification
The bench targets two cases. The first is a concealment request that arrives before any good pair exists; a design that fails to clear its hold storage at reset would emit stale or unknown data there. The second is the release of the lock-loss mute. The bench breaks a qualifying run with a parity error and then feeds clean pairs that come without a block-start marker. A design that counts frames instead of a marked run, or that forgets to restart, would unmute too early. The bench also checks the first unmuted pair exactly, which exposes an off-by-one in the run length. It further checks mid-slot re-enable and each truncation width, where an early enable would emit a partial word and a wrong mask would leak low bits.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

  typedef enum logic [1:0] {
    WL_24 = 2'd0,
    WL_20 = 2'd1,
    WL_18 = 2'd2,
    WL_16 = 2'd3
  } wlen_e;

  typedef struct packed {
    logic par;
    logic bph;
    logic vbit;
    logic blk;
  } pair_flags_t;

  function automatic int kept_bits(input wlen_e w, input int full_w);
    case (w)
      WL_20:   return 20;
      WL_18:   return 18;
      WL_16:   return 16;
      default: return full_w;
    endcase
  endfunction

endpackage

// File: rtl/rxg_bitclk.sv
module rxg_bitclk #(
  parameter int HALF_DIV  = 2,
  parameter int SLOT_BITS = 32
) (
  input  logic clk,
  input  logic rst,
  output logic sck_o,
  output logic ws_o,
  output logic adv,
  output logic decide,
  output logic load
);
  localparam int FRM   = 2 * SLOT_BITS;
  localparam int PH_N  = 2 * HALF_DIV;
  localparam int PH_W  = (PH_N > 1) ? $clog2(PH_N) : 1;
  localparam int CNT_W = $clog2(FRM);

  logic [PH_W-1:0]  ph, ph_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    adv     = (ph == PH_W'(PH_N - 1));
    ph_nxt  = adv ? '0 : ph + 1'b1;
    cnt_nxt = cnt;
    if (adv) cnt_nxt = (cnt == CNT_W'(FRM - 1)) ? '0 : cnt + 1'b1;
    decide  = adv && (cnt == CNT_W'(FRM - 2));
    load    = adv && (cnt == CNT_W'(FRM - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= '0;
      cnt   <= '0;
      sck_o <= 1'b0;
      ws_o  <= 1'b0;
    end else begin
      ph    <= ph_nxt;
      cnt   <= cnt_nxt;
      sck_o <= (ph_nxt >= PH_W'(HALF_DIV));
      ws_o  <= (cnt_nxt >= CNT_W'(SLOT_BITS - 1)) && (cnt_nxt <= CNT_W'(FRM - 2));
    end
  end

  // R1
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ws_o) |-> !sck_o);

endmodule

// File: rtl/rxg_blkqual.sv
module rxg_blkqual #(
  parameter int BLK_FRAMES = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_lock,
  input  logic in_valid,
  input  logic in_err,
  input  logic in_blk_start,
  output logic clean_q
);
  localparam int CW = $clog2(BLK_FRAMES + 1);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run     <= 1'b0;
      cnt     <= '0;
      clean_q <= 1'b0;
    end else begin
      clean_q <= 1'b0;
      if (!pll_lock) begin
        run <= 1'b0;
        cnt <= '0;
      end else if (in_valid) begin
        if (in_err) begin
          run <= 1'b0;
          cnt <= '0;
        end else if (in_blk_start) begin
          run <= 1'b1;
          cnt <= CW'(1);
        end else if (run) begin
          if (cnt == CW'(BLK_FRAMES - 1)) begin
            run     <= 1'b0;
            cnt     <= '0;
            clean_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R6
  clean_lock_chk: assert property (@(posedge clk) disable iff (rst)
    clean_q |-> $past(pll_lock) && $past(in_valid) && !$past(in_err));

endmodule

// File: rtl/rxg_conceal.sv
module rxg_conceal
  import rxg_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  pair_flags_t  in_flags,
  input  logic         pll_lock,
  input  logic         mute_req,
  input  wlen_e        wlen,
  input  logic         decide,
  input  logic         clean,
  output logic [W-1:0] out_l,
  output logic [W-1:0] out_r,
  output logic         out_inv
);
  logic [W-1:0] pend_l, pend_r, hold_l, hold_r, mask;
  logic         pend_v, pend_err, hold_v, lmute, mute_now;
  logic         in_err;

  assign in_err = in_flags.par | in_flags.bph;

  always_comb begin
    mask     = {W{1'b1}} << (W - kept_bits(wlen, W));
    mute_now = mute_req | lmute | ~pll_lock;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l   <= '0;
      pend_r   <= '0;
      pend_v   <= 1'b0;
      pend_err <= 1'b0;
      hold_l   <= '0;
      hold_r   <= '0;
      hold_v   <= 1'b0;
    end else if (in_valid) begin
      pend_l   <= in_left;
      pend_r   <= in_right;
      pend_v   <= in_flags.vbit;
      pend_err <= in_err;
      if (!in_err) begin
        hold_l <= in_left;
        hold_r <= in_right;
        hold_v <= in_flags.vbit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lmute   <= 1'b0;
      out_l   <= '0;
      out_r   <= '0;
      out_inv <= 1'b0;
    end else if (decide) begin
      lmute <= (lmute & ~clean) | ~pll_lock;
      if (mute_now) begin
        out_l   <= '0;
        out_r   <= '0;
        out_inv <= 1'b0;
      end else if (pend_err) begin
        out_l   <= hold_l & mask;
        out_r   <= hold_r & mask;
        out_inv <= hold_v;
      end else begin
        out_l   <= pend_l & mask;
        out_r   <= pend_r & mask;
        out_inv <= pend_v;
      end
    end else if (clean) begin
      lmute <= 1'b0;
    end
  end

  // R5
  lock_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && !pll_lock) |=> (out_l == '0 && out_r == '0 && !out_inv));

  // R7
  cmd_mute_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && mute_req) |=> (out_l == '0 && out_r == '0 && !out_inv));

  // R2
  trunc16_chk: assert property (@(posedge clk) disable iff (rst)
    (decide && wlen == WL_16) |=> (out_l[W-17:0] == '0 && out_r[W-17:0] == '0));

endmodule

// File: rtl/rxg_i2s_ser.sv
module rxg_i2s_ser #(
  parameter int W         = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         load,
  input  logic         port_en,
  input  logic [W-1:0] out_l,
  input  logic [W-1:0] out_r,
  input  logic         out_inv,
  output logic         sd_o,
  output logic         invalid_o
);
  localparam int FRM = 2 * SLOT_BITS;
  localparam int PAD = SLOT_BITS - W;

  logic [FRM-1:0] frame_w, sh;
  logic           en_q, en_nxt;

  always_comb begin
    frame_w = {out_l, {PAD{1'b0}}, out_r, {PAD{1'b0}}};
    en_nxt  = port_en & (en_q | load);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      en_q      <= 1'b0;
      sd_o      <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      en_q <= en_nxt;
      if (load)     sh <= frame_w << 1;
      else if (adv) sh <= sh << 1;
      if (!en_nxt) begin
        sd_o      <= 1'b0;
        invalid_o <= 1'b0;
      end else begin
        if (adv)  sd_o      <= load ? frame_w[FRM-1] : sh[FRM-1];
        if (load) invalid_o <= out_inv;
      end
    end
  end

  // R8
  port_off_chk: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!sd_o && !invalid_o));

endmodule

// File: rtl/rx_audio_guard.sv
module rx_audio_guard
  import rxg_pkg::*;
#(
  parameter int W          = 24,
  parameter int SLOT_BITS  = 32,
  parameter int HALF_DIV   = 2,
  parameter int BLK_FRAMES = 192
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_right,
  input  logic         in_par_err,
  input  logic         in_bph_err,
  input  logic         in_vbit,
  input  logic         in_blk_start,
  input  logic         pll_lock,
  input  logic         mute_req,
  input  logic [1:0]   wlen_sel,
  input  logic         port_en,
  output logic         sck_o,
  output logic         ws_o,
  output logic         sd_o,
  output logic         invalid_o
);
  logic         adv, decide, load, clean;
  logic [W-1:0] sel_l, sel_r;
  logic         sel_inv;
  pair_flags_t  flags;

  assign flags = '{par: in_par_err, bph: in_bph_err, vbit: in_vbit, blk: in_blk_start};

  rxg_bitclk #(.HALF_DIV(HALF_DIV), .SLOT_BITS(SLOT_BITS)) u_clk (
    .clk(clk), .rst(rst), .sck_o(sck_o), .ws_o(ws_o),
    .adv(adv), .decide(decide), .load(load)
  );

  rxg_blkqual #(.BLK_FRAMES(BLK_FRAMES)) u_qual (
    .clk(clk), .rst(rst), .pll_lock(pll_lock), .in_valid(in_valid),
    .in_err(in_par_err | in_bph_err), .in_blk_start(flags.blk), .clean_q(clean)
  );

  rxg_conceal #(.W(W)) u_conceal (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .in_flags(flags), .pll_lock(pll_lock),
    .mute_req(mute_req), .wlen(wlen_e'(wlen_sel)), .decide(decide),
    .clean(clean), .out_l(sel_l), .out_r(sel_r), .out_inv(sel_inv)
  );

  rxg_i2s_ser #(.W(W), .SLOT_BITS(SLOT_BITS)) u_ser (
    .clk(clk), .rst(rst), .adv(adv), .load(load), .port_en(port_en),
    .out_l(sel_l), .out_r(sel_r), .out_inv(sel_inv),
    .sd_o(sd_o), .invalid_o(invalid_o)
  );

endmodule

// File: tb/rx_audio_guard_bench.sv
module rx_audio_guard_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BLK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [23:0] in_left = '0, in_right = '0;
  logic in_par_err = 1'b0, in_bph_err = 1'b0, in_vbit = 1'b0, in_blk_start = 1'b0;
  logic pll_lock = 1'b1, mute_req = 1'b0, port_en = 1'b1;
  logic [1:0] wlen_sel = 2'd0;
  logic sck_o, ws_o, sd_o, invalid_o;

  always #2.5 clk = ~clk;

  rx_audio_guard #(.BLK_FRAMES(BLK)) u_rx_audio_guard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .in_par_err(in_par_err), .in_bph_err(in_bph_err),
    .in_vbit(in_vbit), .in_blk_start(in_blk_start), .pll_lock(pll_lock),
    .mute_req(mute_req), .wlen_sel(wlen_sel), .port_en(port_en),
    .sck_o(sck_o), .ws_o(ws_o), .sd_o(sd_o), .invalid_o(invalid_o)
  );

  int total = 0, bad = 0, cyc = 0;
  bit psck = 0, pws = 0, b_sd = 0, b_ws = 0, b_inv = 0;

  // behavioural model state
  bit m_run = 0, m_lm = 0, h_v = 0;
  int m_cnt = 0;
  logic [23:0] h_l = '0, h_r = '0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: run hung act=%0d exp=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_bit();
    bit got = 0;
    while (!got) begin
      @(negedge clk);
      in_valid = 1'b0;
      if (sck_o && !psck) begin
        pws = b_ws; b_sd = sd_o; b_ws = ws_o; b_inv = invalid_o; got = 1;
      end
      psck = sck_o;
    end
  endtask

  task automatic step(input logic [23:0] l, input logic [23:0] r,
                      input bit par, input bit bph, input bit v, input bit bs,
                      input int reen, input string req);
    logic [23:0] el, er, msk, gl, gr;
    bit ei, gi, err, frm_ok;
    int keep;
    err = par | bph;
    if (!pll_lock) begin m_run = 0; m_cnt = 0; end
    else if (err) begin m_run = 0; m_cnt = 0; end
    else begin
      if (bs) begin m_run = 1; m_cnt = 1; end
      else if (m_run) m_cnt++;
      if (m_run && m_cnt == BLK) begin m_run = 0; m_cnt = 0; m_lm = 0; end
    end
    if (!err) begin h_l = l; h_r = r; h_v = v; end
    m_lm = m_lm | !pll_lock;
    keep = (wlen_sel == 0) ? 24 : (wlen_sel == 1) ? 20 : (wlen_sel == 2) ? 18 : 16;
    msk = 24'hFFFFFF << (24 - keep);
    if (mute_req || m_lm) begin el = 0; er = 0; ei = 0; end
    else if (err) begin el = h_l & msk; er = h_r & msk; ei = h_v; end
    else begin el = l & msk; er = r & msk; ei = v; end
    if (!port_en || reen >= 0) begin el = 0; er = 0; ei = 0; end

    in_left = l; in_right = r; in_par_err = par; in_bph_err = bph;
    in_vbit = v; in_blk_start = bs; in_valid = 1'b1;

    do wait_bit(); while (!(pws == 1 && b_ws == 0));
    gl = '0; gr = '0; gi = 0; frm_ok = 1;
    for (int j = 0; j < 56; j++) begin
      wait_bit();
      if (j == 0) gi = b_inv;
      if (b_ws != (j >= 31)) frm_ok = 0;
      if (j < 24) gl[23-j] = b_sd;
      else if (j < 32) begin if (b_sd) frm_ok = 0; end
      else gr[23-(j-32)] = b_sd;
      if (j == reen) port_en = 1'b1;
    end
    check(frm_ok, "R1", "slot framing", frm_ok, 1);
    check(gl == el, req, "left", gl, el);
    check(gr == er, req, "right", gr, er);
    check(gi == ei, req, "invalid", gi, ei);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    check(!sck_o && !ws_o && !sd_o && !invalid_o, "R9", "outputs after reset",
          {sck_o, ws_o, sd_o, invalid_o}, 0);
    do wait_bit(); while (b_ws != 1);

    // R4: concealment before any good pair gives zero
    step(24'hABCDEF, 24'h123456, 1, 0, 1, 0, -1, "R4");
    step(24'h123456, 24'h654321, 0, 0, 0, 0, -1, "R3");
    step(24'h5A5A5A, 24'hA5A5A5, 0, 0, 1, 0, -1, "R3");
    step(24'h111111, 24'h222222, 1, 0, 0, 0, -1, "R4");
    step(24'h333333, 24'h444444, 0, 1, 0, 0, -1, "R4");
    step(24'h0F0F0F, 24'hF0F0F0, 0, 0, 0, 0, -1, "R3");

    // R2 truncation
    wlen_sel = 2'd1; step(24'hFFFFFF, 24'hABCDEF, 0, 0, 0, 0, -1, "R2");
    wlen_sel = 2'd2; step(24'hFFFFFF, 24'hABCDEF, 0, 0, 0, 0, -1, "R2");
    wlen_sel = 2'd3; step(24'hFFFFFF, 24'hABCDEF, 0, 0, 0, 0, -1, "R2");
    wlen_sel = 2'd0; step(24'hFFFFFF, 24'hABCDEF, 0, 0, 0, 0, -1, "R2");

    // R7 mute command
    mute_req = 1'b1; step(24'h777777, 24'h888888, 0, 0, 1, 0, -1, "R7");
    mute_req = 1'b0; step(24'h999999, 24'hAAAAAA, 0, 0, 0, 0, -1, "R7");

    // R5 lock loss, R6 qualified release
    pll_lock = 1'b0; step(24'h121212, 24'h343434, 0, 0, 0, 0, -1, "R5");
    pll_lock = 1'b1; step(24'h565656, 24'h787878, 0, 0, 0, 0, -1, "R6");
    step(24'h000001, 24'h000002, 0, 0, 0, 1, -1, "R6");
    step(24'h000003, 24'h000004, 0, 0, 0, 0, -1, "R6");
    step(24'h000005, 24'h000006, 0, 0, 0, 0, -1, "R6");
    step(24'h000007, 24'h000008, 1, 0, 0, 0, -1, "R6");
    step(24'h000009, 24'h00000A, 0, 0, 0, 0, -1, "R6");
    step(24'h00000B, 24'h00000C, 0, 0, 0, 0, -1, "R6");
    for (int i = 0; i < BLK; i++)
      step(24'h100000 + i, 24'h200000 + i, 0, 0, 0, (i == 0), -1, "R6");
    step(24'hCAFE01, 24'hBEEF02, 0, 0, 0, 0, -1, "R6");
    step(24'hCAFE03, 24'hBEEF04, 1, 0, 0, 0, -1, "R4");

    // R8 port disable and mid-frame re-enable
    port_en = 1'b0; step(24'h246802, 24'h135791, 0, 0, 1, 0, -1, "R8");
    step(24'h246803, 24'h135792, 0, 0, 1, 0, 4, "R8");
    step(24'h246804, 24'h135793, 0, 0, 1, 0, -1, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule